// File: doc/BRIEF.md
# Size-Aware Integer ALU with Condition Flags

This block is the arithmetic core of a 32-bit integer datapath. It covers add, subtract, compare, a one-place arithmetic shift left, a one-place rotate left through the extend flag, packed-decimal byte add and unsigned 32-by-16 divide. Operands and the result are combinational. A five-bit flag register (extend, negative, zero, overflow, carry) is updated on the clock edge whenever an operation is presented with `op_valid` high.

Each operation works on a byte, a word or a long. Flags look only at the active width, and only the active low bits of the destination are replaced. The bits above them pass through from `dst_opnd`. The datapath reads the extend flag as a carry or rotate input. The carry flag is kept separately, so compare and divide can leave extend alone.

`dst_write` tells the surrounding register file whether `result` should be committed. It is low for compare, for a divide that cannot complete, and for the unused operation code.

Top module: `sized_alu_cc`

## Requirements
- R1: `op_sel` selects 0 add, 1 subtract (dst - src), 2 compare, 3 shift left, 4 rotate left through extend, 5 decimal add, 6 divide. `size_sel` selects 0 byte, 1 word, 2 or 3 long. For add, subtract, shift and rotate, only the active low bits of `result` are computed and the remaining upper bits equal `dst_opnd`. `dst_write` is 1.
- R2: For add, subtract, compare, shift and rotate, N is the active-size MSB of the result. Z is 1 exactly when all active-size result bits are 0.
- R3: For add, V is 1 when both operands share a sign and the result sign differs. For subtract and compare, V is 1 when the dst and src signs differ and the result sign differs from dst.
- R4: C is the carry out of the active MSB for add and the borrow for subtract and compare. Add and subtract also copy C into X.
- R5: Compare holds `dst_write` at 0, drives `result` equal to `dst_opnd`, and leaves X unchanged.
- R6: Shift left moves 0 into bit 0. The old active MSB goes to C and X. V is 1 when the active MSB changes.
- R7: Rotate left moves the old X into bit 0. The old active MSB goes to C and X. V is 0.
- R8: Decimal add sums the low bytes of dst and src plus X as two packed BCD digits, whatever the size. X and C are set when the sum exceeds 99. Z is cleared when the byte is nonzero and kept otherwise. N and V are kept.
- R9: Divide splits `dst_opnd` by `src_opnd[15:0]`. It writes the remainder in bits 31:16 and the quotient in bits 15:0. N is the quotient bit 15, Z is 1 when the quotient is zero, V and C are 0, and X is kept.
- R10: When the quotient exceeds 16 bits or the divisor is zero, divide sets V, clears C, keeps X, N and Z, holds `dst_write` at 0, and passes `dst_opnd` to `result`.
- R11: `ccr` is {X,N,Z,V,C} from bit 4 down to bit 0. A low `rst_n` at a clock edge clears it. It only changes at an edge where `op_valid` is high.
- R12: Operation code 7 drives `dst_write` 0 and `result` equal to `dst_opnd`, and it leaves `ccr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_valid | input | 1 | Commit the new flags at this edge |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Operand size code |
| src_opnd | input | 32 | Source operand |
| dst_opnd | input | 32 | Destination operand (left-hand side) |
| result | output | 32 | Size-merged result |
| dst_write | output | 1 | Result should be committed |
| ccr | output | 5 | Flag register {X,N,Z,V,C} |

## Verification
The assertions assume that `op_sel` and `size_sel` are stable and known while `op_valid` is high. They also assume that reset is applied before flag history matters. The decimal-add checks assume both operand bytes hold valid BCD digits; the bench only ever offers legal digit values. Every vector first loads a known extend flag with a committed add and only then presents the operation. This keeps the flags that the operation should keep at a value the bench already knows.

// File: rtl/alu_cc_pkg.sv
// Shared types and helpers for the size-aware ALU.
// Assumes a 32-bit datapath with byte and word sub-sizes.
package alu_cc_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int SH_W   = $clog2(DATA_W) + 1;
    localparam int DIGIT_W = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_ASL  = 3'd3,
        OP_ROXL = 3'd4,
        OP_ABCD = 3'd5,
        OP_DIVU = 3'd6,
        OP_NONE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // Left shift that brings the active MSB to bit DATA_W-1.
    function automatic logic [SH_W-1:0] align_shift(size_e s);
        case (s)
            SZ_BYTE: return SH_W'(DATA_W - BYTE_W);
            SZ_WORD: return SH_W'(DATA_W - WORD_W);
            default: return '0;
        endcase
    endfunction

    // Mask of the bits that an operation of size s replaces.
    function automatic logic [DATA_W-1:0] size_mask(size_e s);
        return {DATA_W{1'b1}} >> align_shift(s);
    endfunction
endpackage

// File: rtl/alu_addsub.sv
// Add/subtract at a selectable size.
// Operands are aligned so the active MSB sits at the top bit. Carry, borrow
// and sign tests are then the same for every size, and the low bits are zero.
module alu_addsub
    import alu_cc_pkg::*;
(
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  size_e             size,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              n,
    output logic              z,
    output logic              v,
    output logic              c
);
    localparam int M = DATA_W - 1;

    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] d_al, s_al, r_al;
    logic [DATA_W:0]   wide;

    // Aligned arithmetic and flag extraction.
    always_comb begin
        sh   = align_shift(size);
        d_al = dst << sh;
        s_al = src << sh;
        wide = sub ? ({1'b0, d_al} - {1'b0, s_al}) : ({1'b0, d_al} + {1'b0, s_al});
        r_al = wide[DATA_W-1:0];
        res  = r_al >> sh;
        n    = r_al[M];
        z    = (r_al == '0);
        c    = wide[DATA_W];
        if (sub) v = (d_al[M] ^ s_al[M]) & (r_al[M] ^ d_al[M]);
        else     v = ~(d_al[M] ^ s_al[M]) & (r_al[M] ^ d_al[M]);
    end
endmodule

// File: rtl/alu_shift1.sv
// One-place left shift or left rotate through the extend bit, at a selectable size.
// The caller merges away any bits above the active size.
module alu_shift1
    import alu_cc_pkg::*;
(
    input  logic [DATA_W-1:0] dst,
    input  size_e             size,
    input  logic              rotate,
    input  logic              x_in,
    output logic [DATA_W-1:0] res,
    output logic              n,
    output logic              z,
    output logic              v,
    output logic              c
);
    localparam int M = DATA_W - 1;

    logic [SH_W-1:0]   sh;
    logic [DATA_W-1:0] d_al, r_al;

    // Shift, then look at the result aligned to the active MSB.
    always_comb begin
        sh   = align_shift(size);
        d_al = dst << sh;
        res  = {dst[DATA_W-2:0], rotate & x_in};
        r_al = res << sh;
        c    = d_al[M];
        n    = r_al[M];
        z    = (r_al == '0);
        v    = rotate ? 1'b0 : (d_al[M] ^ d_al[M-1]);
    end
endmodule

// File: rtl/alu_bcd.sv
// Packed-BCD byte add with carry-in. Assumes both bytes hold valid digits.
module alu_bcd
    import alu_cc_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    input  logic [BYTE_W-1:0] b,
    input  logic              cin,
    output logic [BYTE_W-1:0] sum,
    output logic              cout
);
    logic [DIGIT_W:0] lo, hi;
    logic             lc;

    // Two ripple digit stages with a +6 correction above nine.
    always_comb begin
        lo = {1'b0, a[DIGIT_W-1:0]} + {1'b0, b[DIGIT_W-1:0]} + {{DIGIT_W{1'b0}}, cin};
        if (lo > 5'd9) lo = lo + 5'd6;
        lc = lo[DIGIT_W];
        hi = {1'b0, a[BYTE_W-1:DIGIT_W]} + {1'b0, b[BYTE_W-1:DIGIT_W]} + {{DIGIT_W{1'b0}}, lc};
        if (hi > 5'd9) hi = hi + 5'd6;
        cout = hi[DIGIT_W];
        sum  = {hi[DIGIT_W-1:0], lo[DIGIT_W-1:0]};
    end
endmodule

// File: rtl/alu_divu.sv
// Unsigned full-width dividend over half-width divisor.
// Flags overflow when the quotient needs more than HALF_W bits or the divisor is zero.
module alu_divu
    import alu_cc_pkg::*;
(
    input  logic [DATA_W-1:0] dividend,
    input  logic [HALF_W-1:0] divisor,
    output logic [DATA_W-1:0] packed_res,
    output logic              ovf
);
    logic [DATA_W-1:0] dvs, quo, rem;

    // Guarded divide and overflow test.
    always_comb begin
        dvs = {{(DATA_W-HALF_W){1'b0}}, divisor};
        if (divisor == '0) begin
            quo = '0;
            rem = '0;
        end else begin
            quo = dividend / dvs;
            rem = dividend % dvs;
        end
        ovf        = (divisor == '0) | (quo[DATA_W-1:HALF_W] != '0);
        packed_res = {rem[HALF_W-1:0], quo[HALF_W-1:0]};
    end
endmodule

// File: rtl/sized_alu_cc.sv
// Size-aware ALU top: picks the operation, merges the result by size,
// and registers the {X,N,Z,V,C} flags when op_valid is high.
// Assumes op_sel and size_sel are stable while op_valid is high. Reset is synchronous, active low.
module sized_alu_cc
    import alu_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic [DATA_W-1:0] dst_opnd,
    output logic [DATA_W-1:0] result,
    output logic              dst_write,
    output logic [4:0]        ccr
);
    op_e   op;
    size_e size;
    ccr_t  ccr_q, ccr_d;

    logic [DATA_W-1:0] as_res, sh_res, dv_res, mask;
    logic [BYTE_W-1:0] bcd_sum;
    logic as_n, as_z, as_v, as_c;
    logic sh_n, sh_z, sh_v, sh_c;
    logic bcd_c, dv_ovf;

    assign op   = op_e'(op_sel);
    assign size = size_e'(size_sel);
    assign mask = size_mask(size);
    assign ccr  = ccr_q;

    alu_addsub u_addsub (
        .dst(dst_opnd), .src(src_opnd), .size(size), .sub(op != OP_ADD),
        .res(as_res), .n(as_n), .z(as_z), .v(as_v), .c(as_c)
    );

    alu_shift1 u_shift (
        .dst(dst_opnd), .size(size), .rotate(op == OP_ROXL), .x_in(ccr_q.x),
        .res(sh_res), .n(sh_n), .z(sh_z), .v(sh_v), .c(sh_c)
    );

    alu_bcd u_bcd (
        .a(dst_opnd[BYTE_W-1:0]), .b(src_opnd[BYTE_W-1:0]), .cin(ccr_q.x),
        .sum(bcd_sum), .cout(bcd_c)
    );

    alu_divu u_divu (
        .dividend(dst_opnd), .divisor(src_opnd[HALF_W-1:0]),
        .packed_res(dv_res), .ovf(dv_ovf)
    );

    // Result selection, size merge and next-flag computation.
    always_comb begin
        result    = dst_opnd;
        dst_write = 1'b0;
        ccr_d     = ccr_q;
        case (op)
            OP_ADD, OP_SUB: begin
                result    = (dst_opnd & ~mask) | (as_res & mask);
                dst_write = 1'b1;
                ccr_d     = '{x: as_c, n: as_n, z: as_z, v: as_v, c: as_c};
            end
            OP_CMP: begin
                ccr_d = '{x: ccr_q.x, n: as_n, z: as_z, v: as_v, c: as_c};
            end
            OP_ASL, OP_ROXL: begin
                result    = (dst_opnd & ~mask) | (sh_res & mask);
                dst_write = 1'b1;
                ccr_d     = '{x: sh_c, n: sh_n, z: sh_z, v: sh_v, c: sh_c};
            end
            OP_ABCD: begin
                result    = {dst_opnd[DATA_W-1:BYTE_W], bcd_sum};
                dst_write = 1'b1;
                ccr_d.x   = bcd_c;
                ccr_d.c   = bcd_c;
                if (bcd_sum != '0) ccr_d.z = 1'b0;
            end
            OP_DIVU: begin
                ccr_d.c = 1'b0;
                ccr_d.v = dv_ovf;
                if (!dv_ovf) begin
                    result    = dv_res;
                    dst_write = 1'b1;
                    ccr_d.n   = dv_res[HALF_W-1];
                    ccr_d.z   = (dv_res[HALF_W-1:0] == '0);
                end
            end
            default: ;
        endcase
    end

    // Flag register: clear on reset, load on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n)        ccr_q <= '0;
        else if (op_valid) ccr_q <= ccr_d;
    end
endmodule

// File: rtl/sized_alu_cc_chk.sv
// Property checker for sized_alu_cc, attached by bind. Observes ports only.
module sized_alu_cc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [2:0]  op_sel,
    input logic [1:0]  size_sel,
    input logic [31:0] src_opnd,
    input logic [31:0] dst_opnd,
    input logic [31:0] result,
    input logic        dst_write,
    input logic [4:0]  ccr
);
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (ccr == 5'd0));

    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(ccr));

    assert_upper_bytes_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_sel <= 3'd1 || op_sel == 3'd3 || op_sel == 3'd4) && size_sel == 2'd0)
            |-> (result[31:8] == dst_opnd[31:8]));

    assert_x_tracks_c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel <= 3'd1 || op_sel == 3'd3 || op_sel == 3'd4))
            |=> (ccr[4] == ccr[0]));

    assert_cmp_keeps_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd2) |=> (ccr[4] == $past(ccr[4])));

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd2) |-> (!dst_write && result == dst_opnd));

    assert_div_overflow_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd6 && !dst_write) |=> (ccr[1] && !ccr[0]));

    assert_unused_op_inert_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 3'd7) |=> $stable(ccr));
endmodule

bind sized_alu_cc sized_alu_cc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .size_sel(size_sel), .src_opnd(src_opnd), .dst_opnd(dst_opnd),
    .result(result), .dst_write(dst_write), .ccr(ccr)
);

// File: tb/sized_alu_cc_test.sv
module sized_alu_cc_test;
    localparam int PERIOD = 10;
    localparam int NVEC   = 23;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sz;
        logic        xin;
        logic [31:0] dst;
        logic [31:0] src;
        logic [31:0] res;
        logic        wr;
        logic [4:0]  ccr;
        logic [3:0]  req;
    } vec_t;

    // ccr expected as {X,N,Z,V,C}; xin selects the preset (1: 0xFF+0x01 -> 10101, 0: 0+0 -> 00100)
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 2'd0, 1'b0, 32'hAABBCCFF, 32'h000000FF, 32'hAABBCCFE, 1'b1, 5'b11001, 4'd1},  // R1 R4 merge + carry
        '{3'd1, 2'd0, 1'b0, 32'h00000012, 32'h00000034, 32'h000000DE, 1'b1, 5'b11001, 4'd4},  // R4 borrow
        '{3'd0, 2'd0, 1'b0, 32'h00000041, 32'h00000046, 32'h00000087, 1'b1, 5'b01010, 4'd3},  // R3 pos+pos
        '{3'd0, 2'd0, 1'b0, 32'h000000DE, 32'h0000009F, 32'h0000007D, 1'b1, 5'b10011, 4'd3},  // R3 neg+neg
        '{3'd1, 2'd0, 1'b0, 32'h00000041, 32'h00000087, 32'h000000BA, 1'b1, 5'b11011, 4'd3},  // R3 pos-neg
        '{3'd1, 2'd0, 1'b0, 32'h00000095, 32'h0000007F, 32'h00000016, 1'b1, 5'b00010, 4'd3},  // R3 neg-pos
        '{3'd0, 2'd1, 1'b0, 32'h1234FFFF, 32'h00000001, 32'h12340000, 1'b1, 5'b10101, 4'd2},  // R2 word zero
        '{3'd0, 2'd2, 1'b1, 32'h12340000, 32'h00005678, 32'h12345678, 1'b1, 5'b00000, 4'd1},  // R1 long
        '{3'd2, 2'd2, 1'b1, 32'h00000005, 32'h00000007, 32'h00000005, 1'b0, 5'b11001, 4'd5},  // R5 cmp less
        '{3'd2, 2'd1, 1'b0, 32'hFFFF0003, 32'h00000003, 32'hFFFF0003, 1'b0, 5'b00100, 4'd5},  // R5 cmp equal word
        '{3'd3, 2'd0, 1'b0, 32'h0000009C, 32'h00000000, 32'h00000038, 1'b1, 5'b10011, 4'd6},  // R6 byte
        '{3'd4, 2'd0, 1'b0, 32'h0000009C, 32'h00000000, 32'h00000038, 1'b1, 5'b10001, 4'd7},  // R7 X=0
        '{3'd4, 2'd0, 1'b1, 32'h11223344, 32'h00000000, 32'h11223389, 1'b1, 5'b01000, 4'd7},  // R7 X=1
        '{3'd3, 2'd2, 1'b0, 32'h40000000, 32'h00000000, 32'h80000000, 1'b1, 5'b01010, 4'd6},  // R6 long
        '{3'd5, 2'd0, 1'b1, 32'h00000099, 32'h00000099, 32'h00000099, 1'b1, 5'b10001, 4'd8},  // R8 99+99+1
        '{3'd5, 2'd2, 1'b1, 32'hABCDEF00, 32'h00000000, 32'hABCDEF01, 1'b1, 5'b00000, 4'd8},  // R8 clears Z
        '{3'd5, 2'd0, 1'b0, 32'h00000050, 32'h00000050, 32'h00000000, 1'b1, 5'b10101, 4'd8},  // R8 keeps Z
        '{3'd6, 2'd2, 1'b0, 32'h000186A1, 32'h00000001, 32'h000186A1, 1'b0, 5'b00110, 4'd10}, // R10 quotient too big
        '{3'd6, 2'd2, 1'b1, 32'h00000064, 32'h00000007, 32'h0002000E, 1'b1, 5'b10000, 4'd9},  // R9 100/7
        '{3'd6, 2'd0, 1'b0, 32'h00000005, 32'h00000000, 32'h00000005, 1'b0, 5'b00110, 4'd10}, // R10 zero divisor
        '{3'd6, 2'd2, 1'b0, 32'h00010000, 32'hFFFF0002, 32'h00008000, 1'b1, 5'b01000, 4'd9},  // R9 upper src ignored
        '{3'd7, 2'd2, 1'b1, 32'h00001234, 32'h00000001, 32'h00001234, 1'b0, 5'b10101, 4'd12}, // R12 unused code
        '{3'd0, 2'd3, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 5'b10101, 4'd1}   // R1 size 3 = long
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_sel;
    logic [1:0]  size_sel;
    logic [31:0] src_opnd, dst_opnd, result;
    logic        dst_write;
    logic [4:0]  ccr;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    sized_alu_cc uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .size_sel(size_sel), .src_opnd(src_opnd), .dst_opnd(dst_opnd),
        .result(result), .dst_write(dst_write), .ccr(ccr)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] d, input logic [31:0] s);
        @(negedge clk);
        op_valid = v; op_sel = op; size_sel = sz; dst_opnd = d; src_opnd = s;
    endtask

    task automatic preset_x(input logic x);
        if (x) drive(1'b1, 3'd0, 2'd0, 32'h000000FF, 32'h00000001);
        else   drive(1'b1, 3'd0, 2'd0, 32'h00000000, 32'h00000000);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        rst_n = 1'b0; op_valid = 1'b0; op_sel = '0; size_sel = '0;
        dst_opnd = '0; src_opnd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "reset ccr", {27'b0, ccr}, 32'h0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            tag = $sformatf("R%0d", VECS[i].req);
            preset_x(VECS[i].xin);
            drive(1'b1, VECS[i].op, VECS[i].sz, VECS[i].dst, VECS[i].src);
            #1;
            check(tag, $sformatf("vec%0d result", i), result, VECS[i].res);
            check(tag, $sformatf("vec%0d write", i), {31'b0, dst_write}, {31'b0, VECS[i].wr});
            @(negedge clk);
            check(tag, $sformatf("vec%0d ccr", i), {27'b0, ccr}, {27'b0, VECS[i].ccr});
            op_valid = 1'b0;
        end

        // R11: flags held while op_valid is low
        preset_x(1'b1);
        drive(1'b0, 3'd0, 2'd0, 32'h0, 32'h0);
        @(negedge clk);
        check("R11", "idle hold", {27'b0, ccr}, 32'h15);

        // R11: synchronous reset mid-run clears the flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "mid reset", {27'b0, ccr}, 32'h0);
        rst_n = 1'b1;

        // R12: unused code leaves flags unchanged when committed after a reset
        drive(1'b1, 3'd7, 2'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);
        @(negedge clk);
        check("R12", "unused after reset", {27'b0, ccr}, 32'h0);
        op_valid = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule